// File: doc/BRIEF.md
# Windowed Channel Enable Selector

This block decides, for each word slot of a time-division frame of up to 128 channels, whether the slot carries data. Channels are grouped into blocks of 16 consecutive channel numbers. Only two blocks are live at any moment. The lower window may point at any even-numbered block, and the upper window may point at any odd-numbered block. A 32-bit mask gives one enable bit to each of the 32 live channels. Its low half covers the lower window and its high half covers the upper window. A channel that falls outside both windows is always disabled. A low slot enable tells the shift logic to release the transmit line to high impedance, or to throw away the received word.

Each slot is presented as a channel index with a valid strobe. The verdict for that slot appears one clock later, and an end-of-block pulse marks the last channel of each 16-channel group. Software watches that pulse and writes new window selectors for the next part of the frame. New selector values are picked up only at a block boundary or at a frame start. Because of this, a write made in the middle of a block never splits that block.

Top module: `chan_window_sel`

## Requirements
- R1: After reset, slot_en_o, slot_vld_o and blk_end_o are 0. Until the first selector load, the lower window is block 0 (channels 0-15) and the upper window is block 1 (channels 16-31).
- R2: slot_vld_o is high exactly in the cycle after a cycle in which slot_vld_i was high. slot_en_o and blk_end_o in that cycle describe the slot presented one cycle earlier.
- R3: A slot whose block number (chan_i divided by 16) equals twice the active lower selector gets slot_en_o = en_mask_i[chan_i mod 16].
- R4: A slot whose block number equals twice the active upper selector plus one gets slot_en_o = en_mask_i[16 + (chan_i mod 16)].
- R5: A slot whose block is in neither active window gets slot_en_o = 0, whatever the mask holds.
- R6: blk_end_o pulses in the cycle after a valid slot whose chan_i mod 16 equals 15, and at no other time.
- R7: The active selectors copy win_lo_sel_i and win_hi_sel_i only at the clock edge of a valid slot with chan_i mod 16 equal to 15, or at an edge where frame_start_i is high. That slot is still judged with the previous selectors, and a selector change at any other time has no effect on slot verdicts.
- R8: In a cycle after one with no valid slot, slot_en_o and blk_end_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld_i | input | 1 | A word slot is presented this cycle |
| chan_i | input | 7 | Channel index of the presented slot |
| frame_start_i | input | 1 | Frame start; also loads the window selectors |
| en_mask_i | input | 32 | Enable bits: [15:0] lower window, [31:16] upper window |
| win_lo_sel_i | input | 2 | Requested lower window; selects block 2*value |
| win_hi_sel_i | input | 2 | Requested upper window; selects block 2*value+1 |
| slot_vld_o | output | 1 | Verdict valid, one cycle after slot_vld_i |
| slot_en_o | output | 1 | Slot enabled (1) or disabled (0) |
| blk_end_o | output | 1 | End-of-block pulse after the 16th channel of a group |

## Verification
Several properties are checked on every cycle. The active selectors hold still between load points and take the requested values at a load. A verdict appears only alongside a valid strobe. The end-of-block pulse follows only a last-in-group slot. A slot outside both windows always comes out disabled. The bench alone can show the correct mask bit for each channel across all window pairings, the reset default windows, and the delayed effect of a selector write made in the middle of a block. For that it sweeps every channel of full frames against an arithmetic model.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_LO   = 2'd1,
    WIN_HI   = 2'd2
  } win_e;
endpackage

// File: rtl/chsel_window_regs.sv
module chsel_window_regs #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEL_W-1:0] lo_req_i,
  input  logic [SEL_W-1:0] hi_req_i,
  output logic [SEL_W-1:0] lo_act_o,
  output logic [SEL_W-1:0] hi_act_o
);
  logic [SEL_W-1:0] lo_q, hi_q, lo_d, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (load_i) begin
      lo_d = lo_req_i;
      hi_d = hi_req_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_act_o = lo_q;
  assign hi_act_o = hi_q;

  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(lo_act_o) && $stable(hi_act_o)));

  assert_sel_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (lo_act_o == $past(lo_req_i) && hi_act_o == $past(hi_req_i)));
endmodule

// File: rtl/chsel_slot_decode.sv
module chsel_slot_decode
  import chsel_pkg::*;
#(
  parameter int CHAN_W  = 7,
  parameter int BLK_LOG = 4,
  parameter int SEL_W   = 2
) (
  input  logic [CHAN_W-1:0]  chan_i,
  input  logic [SEL_W-1:0]   lo_act_i,
  input  logic [SEL_W-1:0]   hi_act_i,
  output win_e               win_o,
  output logic [BLK_LOG-1:0] bit_o,
  output logic               last_o
);
  localparam int BLKN_W = CHAN_W - BLK_LOG;

  logic [BLKN_W-1:0] blk_num;
  logic [1:0]        hit;

  assign blk_num = chan_i[CHAN_W-1:BLK_LOG];
  assign bit_o   = chan_i[BLK_LOG-1:0];
  assign last_o  = &chan_i[BLK_LOG-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_win
    logic [SEL_W-1:0] sel;
    assign sel    = (w == 0) ? lo_act_i : hi_act_i;
    assign hit[w] = (blk_num == {sel, w[0]});
  end

  always_comb begin
    win_o = WIN_NONE;
    if (hit[0])      win_o = WIN_LO;
    else if (hit[1]) win_o = WIN_HI;
  end
endmodule

// File: rtl/chan_window_sel.sv
module chan_window_sel
  import chsel_pkg::*;
#(
  parameter int NUM_CHAN = 128,
  parameter int BLK_SIZE = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_vld_i,
  input  logic [6:0]            chan_i,
  input  logic                  frame_start_i,
  input  logic [2*BLK_SIZE-1:0] en_mask_i,
  input  logic [1:0]            win_lo_sel_i,
  input  logic [1:0]            win_hi_sel_i,
  output logic                  slot_vld_o,
  output logic                  slot_en_o,
  output logic                  blk_end_o
);
  localparam int CHAN_W  = $clog2(NUM_CHAN);
  localparam int BLK_LOG = $clog2(BLK_SIZE);
  localparam int NBLK    = NUM_CHAN / BLK_SIZE;
  localparam int SEL_W   = $clog2(NBLK / 2);

  logic [SEL_W-1:0]   lo_act, hi_act;
  win_e               win;
  logic [BLK_LOG-1:0] bit_idx;
  logic               last_in_blk;
  logic               sel_load;
  logic               vld_d, en_d, end_d;
  logic               vld_q, en_q, end_q;

  assign sel_load = frame_start_i | (slot_vld_i & last_in_blk);

  chsel_window_regs #(.SEL_W(SEL_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (sel_load),
    .lo_req_i (win_lo_sel_i),
    .hi_req_i (win_hi_sel_i),
    .lo_act_o (lo_act),
    .hi_act_o (hi_act)
  );

  chsel_slot_decode #(.CHAN_W(CHAN_W), .BLK_LOG(BLK_LOG), .SEL_W(SEL_W)) dec_i (
    .chan_i   (chan_i),
    .lo_act_i (lo_act),
    .hi_act_i (hi_act),
    .win_o    (win),
    .bit_o    (bit_idx),
    .last_o   (last_in_blk)
  );

  always_comb begin
    vld_d = slot_vld_i;
    en_d  = 1'b0;
    end_d = slot_vld_i & last_in_blk;
    if (slot_vld_i) begin
      case (win)
        WIN_LO:  en_d = en_mask_i[{1'b0, bit_idx}];
        WIN_HI:  en_d = en_mask_i[{1'b1, bit_idx}];
        default: en_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      en_q  <= 1'b0;
      end_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      en_q  <= en_d;
      end_q <= end_d;
    end
  end

  assign slot_vld_o = vld_q;
  assign slot_en_o  = en_q;
  assign blk_end_o  = end_q;

  assert_outside_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld_i && win == WIN_NONE) |=> !slot_en_o);

  assert_end_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end_o |-> ($past(slot_vld_i) && (&$past(chan_i[BLK_LOG-1:0]))));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_vld_o |-> (!slot_en_o && !blk_end_o));

  assert_vld_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld_i |=> slot_vld_o);
endmodule

// File: tb/chan_window_sel_tb.sv
`timescale 1ns/1ps
module chan_window_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slot_vld_i;
  logic [6:0]  chan_i;
  logic        frame_start_i;
  logic [31:0] en_mask_i;
  logic [1:0]  win_lo_sel_i, win_hi_sel_i;
  logic        slot_vld_o, slot_en_o, blk_end_o;

  int checks = 0;
  int failures = 0;
  int exp_lo = 0;
  int exp_hi = 0;

  always #2.5 clk = ~clk;

  chan_window_sel dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_vld_i    (slot_vld_i),
    .chan_i        (chan_i),
    .frame_start_i (frame_start_i),
    .en_mask_i     (en_mask_i),
    .win_lo_sel_i  (win_lo_sel_i),
    .win_hi_sel_i  (win_hi_sel_i),
    .slot_vld_o    (slot_vld_o),
    .slot_en_o     (slot_en_o),
    .blk_end_o     (blk_end_o)
  );

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    slot_vld_i = 1'b0;
    @(negedge clk);
    check("R8", slot_en_o, 1'b0, "idle slot_en");
    check("R8", blk_end_o, 1'b0, "idle blk_end");
    check("R2", slot_vld_o, 1'b0, "idle slot_vld");
  endtask

  task automatic frame_start();
    @(negedge clk);
    slot_vld_i = 1'b0;
    frame_start_i = 1'b1;
    @(negedge clk);
    frame_start_i = 1'b0;
    exp_lo = win_lo_sel_i;
    exp_hi = win_hi_sel_i;
    check("R8", slot_en_o, 1'b0, "frame start slot_en");
  endtask

  task automatic slot(int ch, string force_tag);
    int blk;
    logic exp_en;
    string tag;
    @(negedge clk);
    slot_vld_i = 1'b1;
    chan_i = 7'(ch);
    blk = ch / 16;
    if (blk == 2 * exp_lo) begin
      exp_en = en_mask_i[ch % 16];
      tag = "R3";
    end else if (blk == 2 * exp_hi + 1) begin
      exp_en = en_mask_i[16 + ch % 16];
      tag = "R4";
    end else begin
      exp_en = 1'b0;
      tag = "R5";
    end
    if (force_tag != "") tag = force_tag;
    else if (int'(win_lo_sel_i) != exp_lo || int'(win_hi_sel_i) != exp_hi) tag = "R7";
    @(negedge clk);
    slot_vld_i = 1'b0;
    check(tag, slot_en_o, exp_en, $sformatf("slot_en ch=%0d", ch));
    check("R2", slot_vld_o, 1'b1, "slot_vld");
    check("R6", blk_end_o, (ch % 16 == 15), $sformatf("blk_end ch=%0d", ch));
    if (ch % 16 == 15) begin
      exp_lo = win_lo_sel_i;
      exp_hi = win_hi_sel_i;
    end
  endtask

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    slot_vld_i = 1'b0;
    chan_i = '0;
    frame_start_i = 1'b0;
    en_mask_i = 32'h6B3D_C2F5;
    win_lo_sel_i = 2'd3;
    win_hi_sel_i = 2'd3;
    repeat (3) @(negedge clk);
    check("R1", slot_vld_o, 1'b0, "reset slot_vld");
    check("R1", slot_en_o, 1'b0, "reset slot_en");
    check("R1", blk_end_o, 1'b0, "reset blk_end");
    rst_n = 1'b1;
    // Default windows: block 0 and block 1, requested selectors not yet loaded
    for (int c = 0; c < 15; c++) slot(c, "R1");
    for (int c = 16; c < 20; c++) slot(c - 16 + 16, "");
    idle_check();

    // Sweep every window pairing over full frames, with a mid-block selector write
    for (int fl = 0; fl < 4; fl++) begin
      for (int fh = 0; fh < 4; fh++) begin
        @(negedge clk);
        en_mask_i = 32'h9E37_79B9 ^ (32'h0101_0101 * (fl * 4 + fh)) ^ {fh[7:0], fl[7:0], 16'hA5C3};
        win_lo_sel_i = 2'(fl);
        win_hi_sel_i = 2'(fh);
        frame_start();
        for (int c = 0; c < 128; c++) begin
          if (c == 40) begin
            win_lo_sel_i = 2'((fl + 1) % 4);
            win_hi_sel_i = 2'((fh + 3) % 4);
          end
          slot(c, "");
          if (c % 32 == 7) idle_check();
        end
      end
    end

    // Mask all ones: only the two live windows produce enables
    @(negedge clk);
    en_mask_i = 32'hFFFF_FFFF;
    win_lo_sel_i = 2'd2;
    win_hi_sel_i = 2'd0;
    frame_start();
    for (int c = 0; c < 128; c++) slot(c, "");

    idle_check();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule